// File: doc/BRIEF.md
# Overlapping 1101 Serial Pattern Recognizer

This block watches a single-bit serial stream that advances one bit per clock and flags every place where the four most recent bits, oldest first, read 1, 1, 0, 1. Matches may share bits. The final 1 of one match can serve as the first 1 of the next, so the stream 1101101 yields two hits.

The recognizer is a four-state Mealy machine. Its states are: nothing useful seen, a lone 1 seen, 11 seen, and 110 seen. The detect output is decoded from the present state and the present input bit. It therefore rises in the same cycle as the bit that completes the pattern, before the state register updates at the next edge.

The reset input is asynchronous and active low. Assertion clears the machine at once. Release passes through an internal synchronizer, so bits presented during the first `SYNC_STAGES` clock edges after release are ignored.

Top module: `ser_match1101`

## Requirements
- R1: `detect` is 1 in exactly those cycles where `din` together with the three bits accepted before it (oldest first) form 1,1,0,1. The output is combinational from the present state and `din`.
- R2: From the empty state, `din`=1 advances to the lone-1 state and `din`=0 stays empty. Neither case raises `detect`.
- R3: From the lone-1 state, `din`=1 advances to the 11 state and `din`=0 returns to empty. Neither case raises `detect`.
- R4: A run of ones of any length holds the machine in the 11 state. A run of ones followed by 0,1 gives exactly one detection, on that final 1.
- R5: From the 110 state, `din`=0 returns to empty with `detect`=0. For example, 1100 followed by 1 gives no detection.
- R6: A hit returns the machine to the lone-1 state, so overlapping matches are found. The stream 1101101 gives detections on its 4th and 7th bits.
- R7: `detect` is never high on two consecutive clock cycles.
- R8: While `rst_n` is 0, the machine is held empty and `detect` is 0, even if the machine held 110 and `din`=1. After release, `din` is ignored for `SYNC_STAGES` rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one serial bit is accepted per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| din | input | 1 | Serial data bit |
| detect | output | 1 | High for the cycle in which the present bit completes 1101 |

## Verification
Two functions meet in the same cycle in this block: completing one match and starting the next. The hit cycle must raise `detect` and also leave the machine in the lone-1 state. The bench provokes this with an exhaustive sweep of every 10-bit stream, which contains every overlapping arrangement. It also feeds the directed stream 1101101 and judges each cycle against a four-bit history window computed in the bench. The second collision is reset asserted while a hit is pending. The bench drives 110, then presents 1 with `rst_n` low, and expects `detect` to stay 0.

// File: rtl/ser_match1101_pkg.sv
package ser_match1101_pkg;
  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_EMPTY = 2'd0,
    ST_ONE   = 2'd1,
    ST_TWO   = 2'd2,
    ST_THREE = 2'd3
  } rec_state_e;
endpackage

// File: rtl/ser_match1101_rstsync.sv
module ser_match1101_rstsync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sh_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[LAST-1:0], 1'b1};
      end
    end
  endgenerate

  assign rst_q = sh_q[LAST];
endmodule

// File: rtl/ser_match1101_nxt.sv
module ser_match1101_nxt
  import ser_match1101_pkg::*;
(
  input  rec_state_e cur,
  input  logic       bit_in,
  output rec_state_e nxt,
  output logic       hit
);
  always_comb begin
    nxt = ST_EMPTY;
    hit = 1'b0;
    unique case (cur)
      ST_EMPTY: nxt = bit_in ? ST_ONE : ST_EMPTY;
      ST_ONE:   nxt = bit_in ? ST_TWO : ST_EMPTY;
      ST_TWO:   nxt = bit_in ? ST_TWO : ST_THREE;
      ST_THREE: begin
        nxt = bit_in ? ST_ONE : ST_EMPTY;
        hit = bit_in;
      end
      default:  nxt = ST_EMPTY;
    endcase
  end
endmodule

// File: rtl/ser_match1101_streg.sv
module ser_match1101_streg
  import ser_match1101_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  rec_state_e d,
  output rec_state_e q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= ST_EMPTY;
    else        q <= d;
  end
endmodule

// File: rtl/ser_match1101.sv
module ser_match1101
  import ser_match1101_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic detect
);
  logic       rst_q;
  rec_state_e cur_state;
  rec_state_e nxt_state;
  logic       hit;

  ser_match1101_rstsync #(.SYNC_STAGES(SYNC_STAGES)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  ser_match1101_nxt u_nxt (
    .cur    (cur_state),
    .bit_in (din),
    .nxt    (nxt_state),
    .hit    (hit)
  );

  ser_match1101_streg u_reg (
    .clk   (clk),
    .rst_n (rst_q),
    .d     (nxt_state),
    .q     (cur_state)
  );

  assign detect = hit;
endmodule

// File: rtl/ser_match1101_chk.sv
module ser_match1101_chk
  import ser_match1101_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       rst_q,
  input logic       din,
  input logic       detect,
  input rec_state_e state
);
  p_empty_one_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (state == ST_EMPTY && din) |=> state == ST_ONE);

  p_one_zero_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (state == ST_ONE && !din) |=> state == ST_EMPTY);

  p_ones_hold_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (state == ST_TWO && din) |=> state == ST_TWO);

  p_three_zero_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (state == ST_THREE && !din) |=> (state == ST_EMPTY && !detect));

  p_hit_overlap_r6: assert property (@(posedge clk) disable iff (!rst_q)
    detect |=> state == ST_ONE);

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_q)
    detect |=> !detect);

  p_reset_quiet_r8: assert property (@(posedge clk)
    !rst_n |-> (!detect && state == ST_EMPTY));
endmodule

bind ser_match1101 ser_match1101_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .rst_q  (rst_q),
  .din    (din),
  .detect (detect),
  .state  (cur_state)
);

// File: tb/ser_match1101_tb.sv
`timescale 1ns/1ps
module ser_match1101_tb;
  localparam int SYNC = 2;
  localparam int LEN  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0;
  logic detect;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [2:0] hist = '0;
  int nacc = 0;
  logic prev_det = 1'b0;

  always #4 clk = ~clk;

  ser_match1101 #(.SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .din(din), .detect(detect)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: detect=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; din = 1'b1;
    #1 check(detect, 1'b0, "R8 reset low");
    @(negedge clk);
    din = 1'b0;
    rst_n = 1'b1;
    repeat (SYNC - 1) @(negedge clk);
    hist = '0; nacc = 0; prev_det = 1'b0;
  endtask

  task automatic feed(input logic b, input string tag);
    logic exp;
    @(negedge clk);
    din = b;
    #1;
    exp = (nacc >= 3) && ({hist, b} == 4'b1101);
    check(detect, exp, tag);
    if (prev_det && detect) begin
      checks++; errors++;
      $display("FAIL R7: detect=1 expected 0 after a hit");
    end
    prev_det = detect;
    hist = {hist[1:0], b};
    nacc++;
  endtask

  task automatic run_seq(input logic [15:0] bits, input int n, input string tag);
    do_reset();
    for (int i = n - 1; i >= 0; i--) feed(bits[i], tag);
  endtask

  initial begin
    int hits;
    // R8: state after reset, ignored bits during synchronizer window
    do_reset();
    @(negedge clk); #1 check(detect, 1'b0, "R8 idle after release");

    // R2 / R3 directed
    run_seq(16'b0000_0001, 8, "R2 empty transitions");
    run_seq(16'b0101_0101, 8, "R3 lone-one transitions");
    // R4 run of ones then 0,1
    run_seq(16'b0111_1111_1101, 12, "R4 ones run");
    // R5
    run_seq(16'b11001, 5, "R5 110 then 0");
    // R6 overlap: count detections
    do_reset();
    hits = 0;
    for (int i = 6; i >= 0; i--) begin
      feed(7'b1101101 >> i & 1'b1, "R6 overlap");
      if (detect) hits++;
    end
    checks++;
    if (hits != 2) begin
      errors++;
      $display("FAIL R6: hits=%0d expected 2", hits);
    end

    // R8: reset asserted while a hit is pending
    do_reset();
    feed(1'b1, "R8 pre"); feed(1'b1, "R8 pre"); feed(1'b0, "R8 pre");
    @(negedge clk);
    din = 1'b1; rst_n = 1'b0;
    #1 check(detect, 1'b0, "R8 reset over pending hit");
    @(negedge clk);
    rst_n = 1'b1; din = 1'b0;
    repeat (SYNC - 1) @(negedge clk);
    hist = '0; nacc = 0; prev_det = 1'b0;
    feed(1'b1, "R8 fresh after reset");

    // R1: exhaustive sweep of all LEN-bit streams
    for (int s = 0; s < (1 << LEN); s++) begin
      do_reset();
      for (int i = LEN - 1; i >= 0; i--) feed(s[i], "R1 sweep");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule